// File: doc/BRIEF.md
# Write-Only Serial Bus Slave Receiver

This block is the receive front end of a display-driver controller that sits on a two-wire serial bus (I2C-style signalling). It never reads back and never starts a transfer. It watches SCL and SDA and cleans both through a synchroniser and a majority filter. It finds START and STOP conditions and clocks in an address byte, most significant bit first. It then decides whether the transfer is meant for it. Only a write to the 7-bit address `011100x` is accepted. The last address bit `x` comes from the `sa0_i` strap pin, so two such receivers can share one bus. An accepted address is acknowledged. Every following data byte is acknowledged and handed to the core logic with a one-cycle strobe.

The only thing the block places on SDA is an acknowledge. This is an active-high pull-low enable that an open-drain pad turns into a low level. Several receivers with the same strap level can therefore acknowledge together. A read request, or an address that does not match, makes the block go silent until the next START.

Top module: `i2cw_slave_rx`

## Requirements
- R1: After reset `sda_pull_o` and `rx_valid_o` are 0, and no START has been seen.
- R2: An address byte with bits 7..1 equal to `0111 00` followed by the `sa0_i` level, and bit 0 (the read/write flag) equal to 0, is acknowledged: `sda_pull_o` is 1 while SCL is high in the ninth clock.
- R3: An address byte whose upper seven bits differ from that value is not acknowledged. No data byte of that transfer is acknowledged or presented until a new START.
- R4: An address byte that matches but has bit 0 equal to 1 (read) is not acknowledged, and the rest of the transfer is ignored.
- R5: After an accepted address, each 8-bit data byte (first bit received is bit 7) appears on `rx_data_o` with `rx_valid_o` high, and is acknowledged in its ninth clock.
- R6: `sda_pull_o` changes only after a falling edge of filtered SCL, a START or a STOP. It is released after the falling edge that ends the ninth clock, and it never disturbs SDA during the eight data clocks.
- R7: A START seen in the middle of a transfer clears the bit count and restarts address reception. Partly received bits are dropped.
- R8: After a STOP the block is idle. Clock pulses without a new START are not acknowledged and present no data.
- R9: An SCL pulse that lasts one system clock is rejected by the majority filter and does not count as a bit.
- R10: `rx_valid_o` is high for exactly one system clock per byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| sa0_i | input | 1 | Strap pin giving the lowest address bit |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge), 0 = release |
| rx_data_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe marking a new data byte |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser and a three-tap majority filter. This gives a pipeline of about five system clocks between a pad edge and the receive logic. Each bus quarter-period is 20 system clocks, which keeps every condition clear of that latency. Because the filter has three taps, a one-clock SCL spike can be injected inside a low phase to show that it is rejected. The strap pin is randomised per transfer, so both address variants and the mismatch against the other receiver's address are covered.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

   typedef enum logic [2:0] {
      RX_IDLE   = 3'd0,
      RX_ADDR   = 3'd1,
      RX_AACK   = 3'd2,
      RX_DATA   = 3'd3,
      RX_DACK   = 3'd4,
      RX_IGNORE = 3'd5
   } rx_state_e;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2cw_sync_filt.sv
module i2cw_sync_filt #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_TAPS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pad_i,
   output logic clean_o
);

   initial begin
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
      if (FILT_TAPS % 2 == 0) $error("FILT_TAPS must be odd");
   end

   localparam int unsigned MAJ = FILT_TAPS / 2;

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pad_i};
   end

   generate
      if (FILT_TAPS == 1) begin : g_nofilt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) clean_o <= 1'b1;
            else        clean_o <= sync_q[SYNC_STAGES-1];
         end
      end else begin : g_major
         logic [FILT_TAPS-1:0] hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q  <= '1;
               clean_o <= 1'b1;
            end else begin
               hist_q  <= {hist_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
               clean_o <= ($countones(hist_q) > MAJ);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/i2cw_cond_det.sv
module i2cw_cond_det (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   always_comb begin
      scl_rise  = scl_f & ~scl_q;
      scl_fall  = ~scl_f & scl_q;
      start_det = scl_f & scl_q & sda_q & ~sda_f;
      stop_det  = scl_f & scl_q & ~sda_q & sda_f;
   end

endmodule

// File: rtl/i2cw_rx_fsm.sv
module i2cw_rx_fsm
   import i2cw_pkg::*;
#(
   parameter int unsigned      ADDR_W  = 7,
   parameter logic [ADDR_W-2:0] ADDR_HI = 6'b011100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_f,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sa0,
   output logic              sda_pull,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid
);

   initial begin
      if (ADDR_W + 1 != BYTE_W) $error("address plus R/W must fill one byte");
   end

   localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

   rx_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] sh_q;
   logic              addr_hit;

   always_comb begin
      addr_hit = (sh_q[BYTE_W-1:1] == {ADDR_HI, sa0}) && !sh_q[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= RX_IDLE;
         cnt_q    <= '0;
         sh_q     <= '0;
         sda_pull <= 1'b0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (start_det) begin
            state_q  <= RX_ADDR;
            cnt_q    <= '0;
            sda_pull <= 1'b0;
         end else if (stop_det) begin
            state_q  <= RX_IDLE;
            cnt_q    <= '0;
            sda_pull <= 1'b0;
         end else begin
            case (state_q)
               RX_ADDR, RX_DATA: begin
                  if (scl_rise && cnt_q < LAST) begin
                     sh_q  <= {sh_q[BYTE_W-2:0], sda_f};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall && cnt_q == LAST) begin
                     if (state_q == RX_ADDR) begin
                        if (addr_hit) begin
                           sda_pull <= 1'b1;
                           state_q  <= RX_AACK;
                        end else begin
                           state_q  <= RX_IGNORE;
                        end
                     end else begin
                        sda_pull <= 1'b1;
                        rx_data  <= sh_q;
                        rx_valid <= 1'b1;
                        state_q  <= RX_DACK;
                     end
                  end
               end
               RX_AACK, RX_DACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     cnt_q    <= '0;
                     state_q  <= RX_DATA;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2cw_slave_rx.sv
module i2cw_slave_rx #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_TAPS   = 3,
   parameter int unsigned ADDR_W      = 7,
   parameter logic [ADDR_W-2:0] ADDR_HI = 6'b011100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic       sa0_i,
   output logic       sda_pull_o,
   output logic [7:0] rx_data_o,
   output logic       rx_valid_o
);

   logic scl_f, sda_f;
   logic scl_rise, scl_fall, start_det, stop_det;

   i2cw_sync_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_TAPS(FILT_TAPS)) u_scl (
      .clk(clk), .rst_n(rst_n), .pad_i(scl_i), .clean_o(scl_f)
   );

   i2cw_sync_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_TAPS(FILT_TAPS)) u_sda (
      .clk(clk), .rst_n(rst_n), .pad_i(sda_i), .clean_o(sda_f)
   );

   i2cw_cond_det u_cond (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2cw_rx_fsm #(.ADDR_W(ADDR_W), .ADDR_HI(ADDR_HI)) u_rx (
      .clk(clk), .rst_n(rst_n), .sda_f(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sa0(sa0_i),
      .sda_pull(sda_pull_o), .rx_data(rx_data_o), .rx_valid(rx_valid_o)
   );

endmodule

// File: rtl/i2cw_rx_chk.sv
module i2cw_rx_chk
   import i2cw_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input rx_state_e state_q,
   input logic      sda_pull,
   input logic      rx_valid,
   input logic      scl_fall,
   input logic      start_det,
   input logic      stop_det
);

   // R10
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R6
   pull_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> $past(scl_fall));

   // R6
   pull_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull) |-> $past(scl_fall || start_det || stop_det));

   // R3
   ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_IGNORE) |-> !sda_pull);

   // R5
   valid_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> sda_pull);

   // R7
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state_q == RX_ADDR) && !sda_pull);

   // R8
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> (state_q == RX_IDLE) && !sda_pull);

endmodule

bind i2cw_rx_fsm i2cw_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .state_q(state_q), .sda_pull(sda_pull),
   .rx_valid(rx_valid), .scl_fall(scl_fall),
   .start_det(start_det), .stop_det(stop_det)
);

// File: tb/i2cw_slave_rx_test.sv
`timescale 1ns/1ps
module i2cw_slave_rx_test;

   localparam int Q = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, glitch = 1'b0, sa0 = 1'b0;
   logic sda_pull, rx_valid;
   logic [7:0] rx_data;
   wire  sda_line = sda_m & ~sda_pull;
   wire  scl_line = scl_m | glitch;

   int checks = 0, fails = 0, cap_n = 0, dbl_valid = 0;
   logic [7:0] cap [0:1023];
   logic [7:0] expb [0:15];
   logic prev_valid = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   i2cw_slave_rx uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .sa0_i(sa0), .sda_pull_o(sda_pull), .rx_data_o(rx_data),
      .rx_valid_o(rx_valid)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         if (cap_n < 1024) cap[cap_n] = rx_data;
         cap_n++;
      end
      if (rx_valid && prev_valid) dbl_valid++;
      prev_valid = rx_valid;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   function automatic bit exp_hit(input logic [6:0] a, input bit rw, input logic s);
      return (a == {6'b011100, s}) && !rw;
   endfunction

   task automatic start_cond();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic stop_cond();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic send_bit(input bit b, input bit glt);
      sda_m = b;
      if (glt) begin
         repeat (Q/2) @(negedge clk);
         glitch = 1'b1; @(negedge clk); glitch = 1'b0;
         repeat (Q - Q/2 - 1) @(negedge clk);
      end else wq();
      scl_m = 1'b1; wq();
      // R6: no pull during data clocks
      chk(sda_line == sda_m, "R6", sda_line, sda_m);
      wq(); scl_m = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] v, input bit glt, output bit ack);
      for (int i = 7; i >= 0; i--) send_bit(v[i], glt && i == 4);
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
      ack = !sda_line;
      wq(); scl_m = 1'b0; wq();
      // R6: released after ninth falling edge
      chk(sda_line == 1'b1, "R6", sda_line, 1);
   endtask

   task automatic xfer(input logic [6:0] a, input bit rw, input int n,
                       input bit glt, input bit do_stop);
      bit ack, hit;
      int base, k;
      string rq;
      hit = exp_hit(a, rw, sa0);
      rq = hit ? "R2" : (a == {6'b011100, sa0} ? "R4" : "R3");
      start_cond();
      send_byte({a, rw}, 1'b0, ack);
      chk(ack == hit, rq, ack, hit);
      base = cap_n; k = 0;
      for (int i = 0; i < n; i++) begin
         logic [7:0] b;
         b = 8'($urandom);
         send_byte(b, glt, ack);
         chk(ack == hit, hit ? "R5" : rq, ack, hit);
         if (hit) begin expb[k] = b; k++; end
      end
      chk(cap_n - base == k, hit ? "R5" : rq, cap_n - base, k);
      for (int i = 0; i < k && base + i < 1024; i++)
         chk(cap[base+i] == expb[i], glt ? "R9" : "R5", cap[base+i], expb[i]);
      if (do_stop) stop_cond();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      bit ack;
      int base;
      void'($urandom(32'h1c2b));
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(sda_pull == 1'b0, "R1", sda_pull, 0);
      chk(rx_valid == 1'b0, "R1", rx_valid, 0);
      rst_n = 1'b1;
      wq();
      chk(sda_pull == 1'b0 && cap_n == 0, "R1", sda_pull, 0);

      // directed: both strap levels
      sa0 = 1'b0; xfer(7'b0111000, 1'b0, 2, 1'b0, 1'b1);
      sa0 = 1'b1; xfer(7'b0111001, 1'b0, 1, 1'b0, 1'b1);
      // R3: other receiver's address
      xfer(7'b0111000, 1'b0, 2, 1'b0, 1'b1);
      // R4: read request
      xfer(7'b0111001, 1'b1, 2, 1'b0, 1'b1);
      // R9: one-clock SCL spike in a low phase
      xfer(7'b0111001, 1'b0, 2, 1'b1, 1'b1);

      // R7: repeated START inside a data byte
      start_cond();
      send_byte(8'b0111_0010, 1'b0, ack);
      chk(ack, "R7", ack, 1);
      base = cap_n;
      for (int i = 0; i < 5; i++) send_bit(i[0], 1'b0);
      xfer(7'b0111001, 1'b0, 1, 1'b0, 1'b0);
      chk(cap_n - base == 1, "R7", cap_n - base, 1);
      // R7: restart to a foreign address silences the rest
      xfer(7'b1010101, 1'b0, 1, 1'b0, 1'b1);

      // R8: clocking after STOP with no START
      scl_m = 1'b0; wq();
      base = cap_n;
      send_byte(8'b0111_0010, 1'b0, ack);
      chk(!ack, "R8", ack, 0);
      send_byte(8'hA5, 1'b0, ack);
      chk(!ack && cap_n == base, "R8", cap_n - base, 0);
      scl_m = 1'b1; wq();

      // random mix
      for (int t = 0; t < 40; t++) begin
         logic [6:0] a;
         sa0 = 1'($urandom);
         a = ($urandom % 2) ? {6'b011100, 1'($urandom)} : 7'($urandom);
         xfer(a, ($urandom % 5) == 0, $urandom % 3, 1'b0, ($urandom % 4) != 0);
      end
      stop_cond();

      // R10: valid pulses single-cycle
      chk(dbl_valid == 0, "R10", dbl_valid, 0);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule